// File: doc/BRIEF.md
# RV32 Register-Format Instruction Decoder

This block is the decode stage of a small 32-bit RISC-V core. It takes one 32-bit instruction word per cycle, marked by a valid strobe. The valid strobe also acts as the load enable for the decode results. For the register-register opcode group it produces four things:

- the destination register index;
- the two source register indices, placed on operand outputs a and b;
- a 4-bit operation code;
- a 5-bit operation class, which sends the instruction either to the arithmetic unit or to the multiply/divide/shift unit.

For every word it also extracts the U, I (sign- and zero-extended) and B immediates.

All results are registered. A one-cycle decode-valid pulse appears on the clock edge after the strobe. Opcodes other than the register-register group are flagged as illegal, so that a later stage can trap on them.

Shifts are sent to the multiply/divide/shift unit, not to the arithmetic unit. Any word with instruction bit 25 set is also sent to that unit. In that case funct3 (bits 14:12) picks one of eight multiply/divide operations. Operand outputs a and b carry register indices, not register data. Reading the register file belongs to the next stage.

Top module: `rv_rtype_decoder`

## Requirements
- R1: The decode-valid output is high in the cycle after each clock edge that samples the input strobe high, and low otherwise. It is low while the active-low reset is asserted and right after reset, with every other output zero.
- R2: For a word whose bits 6:0 equal 0110011, the outputs are zero-extended copies of instruction fields: the destination index is bits 11:7, operand a is bits 19:15 and operand b is bits 24:20. Operand c is always zero.
- R3: A register-register word with funct3 equal to 001 or 101, or with bit 25 set, has class 1 (multiply/divide/shift).
- R4: With bit 25 clear, funct3 001 gives operation 7 (shift left logical). Funct3 101 gives operation 9 (shift right arithmetic) when bit 30 is set, and operation 8 (shift right logical) otherwise.
- R5: With bit 25 set, the operation code equals funct3 (0 to 7), whatever the value of bit 30.
- R6: With bit 25 clear and funct3 not 001 or 101, the class is 0 (arithmetic). The operation codes are as follows, and all funct7 bits other than bit 30 are ignored:

  | funct3 | Operation | Code |
  |--------|-----------|------|
  | 000, bit 30 clear | ADD | 0 |
  | 000, bit 30 set | SUB | 1 |
  | 111 | AND | 2 |
  | 110 | OR | 3 |
  | 100 | XOR | 4 |
  | 010 | signed less-than | 5 |
  | 011 | unsigned less-than | 6 |

- R7: The U immediate output is bits 31:12 followed by twelve zeros, for every decoded word.
- R8: The I immediate is bits 31:20. It is output twice, once sign-extended and once zero-extended to 32 bits, for every decoded word.
- R9: The B immediate output is {bit 31, bit 7, bits 30:25, bits 11:8, 0}, sign-extended from bit 12, for every decoded word.
- R10: A word whose bits 6:0 differ from 0110011 sets the illegal flag. For that word the class, operation code, destination index and operands a and b are all zero.
- R11: When the strobe is low, all decode outputs keep their previous values, whatever is on the instruction input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| instr_i | input | 32 | Instruction word |
| instr_valid_i | input | 1 | Instruction word is valid this cycle |
| dec_valid_o | output | 1 | One-cycle pulse: decode outputs are fresh |
| illegal_o | output | 1 | Opcode is outside the supported group |
| op_class_o | output | 5 | 0 = arithmetic, 1 = multiply/divide/shift |
| op_code_o | output | 4 | Operation code within the class |
| rd_idx_o | output | 6 | Destination register index |
| op_a_o | output | 32 | First source register index, zero-extended |
| op_b_o | output | 32 | Second source register index, zero-extended |
| op_c_o | output | 32 | Immediate operand, zero for register-format words |
| imm_u_o | output | 32 | U immediate |
| imm_i_s_o | output | 32 | I immediate, sign-extended |
| imm_i_u_o | output | 32 | I immediate, zero-extended |
| imm_b_o | output | 32 | B immediate, sign-extended |

## Verification
The bench builds the decoder with its default parameters: a 32-bit word, a 6-bit destination index, a 4-bit operation code and a 5-bit class. These are the widths that the core's execution units decode.

With these widths, the bench's independent model can compare every output bit-for-bit. That covers both ends of every immediate's sign extension and the zero padding of the 5-bit register fields into the wider outputs.

The random words are split evenly between the register-register opcode and arbitrary opcodes. This reaches all eight funct3 values, with bits 25 and 30 in all four combinations, as well as the illegal path.

// File: rtl/rv_dec_pkg.sv
package rv_dec_pkg;

  localparam logic [6:0] OPC_REG_REG = 7'b0110011;

  typedef enum logic [3:0] {
    OPC_ADD = 4'd0,
    OPC_SUB = 4'd1,
    OPC_AND = 4'd2,
    OPC_OR  = 4'd3,
    OPC_XOR = 4'd4,
    OPC_SLT = 4'd5,
    OPC_SLTU = 4'd6,
    OPC_SLL = 4'd7,
    OPC_SRL = 4'd8,
    OPC_SRA = 4'd9
  } rr_op_e;

  typedef enum logic [4:0] {
    CLS_ARITH = 5'd0,
    CLS_MDS   = 5'd1
  } rr_class_e;

endpackage

// File: rtl/rv_imm_extract.sv
module rv_imm_extract #(
  parameter int XLEN = 32
) (
  input  logic [31:0]     instr_i,
  output logic [XLEN-1:0] imm_u_o,
  output logic [XLEN-1:0] imm_i_s_o,
  output logic [XLEN-1:0] imm_i_u_o,
  output logic [XLEN-1:0] imm_b_o
);

  localparam int IMM_I_W = 12;
  localparam int IMM_B_W = 13;

  logic [IMM_I_W-1:0] raw_i;
  logic [IMM_B_W-1:0] raw_b;
  logic [31:0]        raw_u;

  always_comb begin
    raw_i = instr_i[31:20];
    raw_b = {instr_i[31], instr_i[7], instr_i[30:25], instr_i[11:8], 1'b0};
    raw_u = {instr_i[31:12], 12'b0};
    imm_u_o   = XLEN'($signed(raw_u));
    imm_i_s_o = XLEN'($signed(raw_i));
    imm_i_u_o = XLEN'(raw_i);
    imm_b_o   = XLEN'($signed(raw_b));
  end

endmodule

// File: rtl/rv_rr_classify.sv
module rv_rr_classify
  import rv_dec_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int REG_IDX_W = 6,
  parameter int OP_W      = 4,
  parameter int CLASS_W   = 5
) (
  input  logic [31:0]          instr_i,
  output logic                 illegal_o,
  output logic [CLASS_W-1:0]   class_o,
  output logic [OP_W-1:0]      op_o,
  output logic [REG_IDX_W-1:0] rd_o,
  output logic [XLEN-1:0]      src_a_o,
  output logic [XLEN-1:0]      src_b_o
);

  logic [2:0] funct3;
  logic       alt_bit;
  logic       mds_bit;
  rr_op_e     op_sel;
  rr_class_e  cls_sel;

  always_comb begin
    funct3  = instr_i[14:12];
    alt_bit = instr_i[30];
    mds_bit = instr_i[25];
    op_sel  = OPC_ADD;
    cls_sel = CLS_ARITH;
    unique case (funct3)
      3'b000: op_sel = alt_bit ? OPC_SUB : OPC_ADD;
      3'b001: begin op_sel = OPC_SLL; cls_sel = CLS_MDS; end
      3'b010: op_sel = OPC_SLT;
      3'b011: op_sel = OPC_SLTU;
      3'b100: op_sel = OPC_XOR;
      3'b101: begin op_sel = alt_bit ? OPC_SRA : OPC_SRL; cls_sel = CLS_MDS; end
      3'b110: op_sel = OPC_OR;
      default: op_sel = OPC_AND;
    endcase
  end

  always_comb begin
    illegal_o = 1'b1;
    class_o   = '0;
    op_o      = '0;
    rd_o      = '0;
    src_a_o   = '0;
    src_b_o   = '0;
    if (instr_i[6:0] == OPC_REG_REG) begin
      illegal_o = 1'b0;
      rd_o      = REG_IDX_W'(instr_i[11:7]);
      src_a_o   = XLEN'(instr_i[19:15]);
      src_b_o   = XLEN'(instr_i[24:20]);
      if (mds_bit) begin
        class_o = CLASS_W'(CLS_MDS);
        op_o    = OP_W'(funct3);
      end else begin
        class_o = CLASS_W'(cls_sel);
        op_o    = OP_W'(op_sel);
      end
    end
  end

endmodule

// File: rtl/rv_dec_hold_reg.sv
module rv_dec_hold_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] q_next;

  always_comb begin
    q_next = en_i ? d_i : q_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= q_next;
  end

endmodule

// File: rtl/rv_rtype_decoder.sv
module rv_rtype_decoder #(
  parameter int XLEN      = 32,
  parameter int REG_IDX_W = 6,
  parameter int OP_W      = 4,
  parameter int CLASS_W   = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [31:0]          instr_i,
  input  logic                 instr_valid_i,
  output logic                 dec_valid_o,
  output logic                 illegal_o,
  output logic [CLASS_W-1:0]   op_class_o,
  output logic [OP_W-1:0]      op_code_o,
  output logic [REG_IDX_W-1:0] rd_idx_o,
  output logic [XLEN-1:0]      op_a_o,
  output logic [XLEN-1:0]      op_b_o,
  output logic [XLEN-1:0]      op_c_o,
  output logic [XLEN-1:0]      imm_u_o,
  output logic [XLEN-1:0]      imm_i_s_o,
  output logic [XLEN-1:0]      imm_i_u_o,
  output logic [XLEN-1:0]      imm_b_o
);

  localparam int IMM_W = 4 * XLEN;
  localparam int CTL_W = 1 + CLASS_W + OP_W + REG_IDX_W + 2 * XLEN;

  logic                 c_illegal;
  logic [CLASS_W-1:0]   c_class;
  logic [OP_W-1:0]      c_op;
  logic [REG_IDX_W-1:0] c_rd;
  logic [XLEN-1:0]      c_a;
  logic [XLEN-1:0]      c_b;
  logic [XLEN-1:0]      c_imm_u;
  logic [XLEN-1:0]      c_imm_is;
  logic [XLEN-1:0]      c_imm_iu;
  logic [XLEN-1:0]      c_imm_b;
  logic [CTL_W-1:0]     ctl_d;
  logic [CTL_W-1:0]     ctl_q;
  logic [IMM_W-1:0]     imm_d;
  logic [IMM_W-1:0]     imm_q;
  logic [0:0]           vld_q;

  rv_rr_classify #(
    .XLEN(XLEN), .REG_IDX_W(REG_IDX_W), .OP_W(OP_W), .CLASS_W(CLASS_W)
  ) u_classify (
    .instr_i  (instr_i),
    .illegal_o(c_illegal),
    .class_o  (c_class),
    .op_o     (c_op),
    .rd_o     (c_rd),
    .src_a_o  (c_a),
    .src_b_o  (c_b)
  );

  rv_imm_extract #(.XLEN(XLEN)) u_imm (
    .instr_i  (instr_i),
    .imm_u_o  (c_imm_u),
    .imm_i_s_o(c_imm_is),
    .imm_i_u_o(c_imm_iu),
    .imm_b_o  (c_imm_b)
  );

  always_comb begin
    ctl_d = {c_illegal, c_class, c_op, c_rd, c_a, c_b};
    imm_d = {c_imm_u, c_imm_is, c_imm_iu, c_imm_b};
  end

  rv_dec_hold_reg #(.W(CTL_W)) u_ctl_reg (
    .clk(clk), .rst_n(rst_n), .en_i(instr_valid_i), .d_i(ctl_d), .q_o(ctl_q)
  );

  rv_dec_hold_reg #(.W(IMM_W)) u_imm_reg (
    .clk(clk), .rst_n(rst_n), .en_i(instr_valid_i), .d_i(imm_d), .q_o(imm_q)
  );

  rv_dec_hold_reg #(.W(1)) u_vld_reg (
    .clk(clk), .rst_n(rst_n), .en_i(1'b1), .d_i(instr_valid_i), .q_o(vld_q)
  );

  always_comb begin
    dec_valid_o = vld_q[0];
    {illegal_o, op_class_o, op_code_o, rd_idx_o, op_a_o, op_b_o} = ctl_q;
    {imm_u_o, imm_i_s_o, imm_i_u_o, imm_b_o} = imm_q;
    op_c_o = '0;
  end

endmodule

// File: rtl/rv_rtype_decoder_chk.sv
module rv_rtype_decoder_chk #(
  parameter int XLEN      = 32,
  parameter int REG_IDX_W = 6,
  parameter int OP_W      = 4,
  parameter int CLASS_W   = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [31:0]          instr_i,
  input logic                 instr_valid_i,
  input logic                 dec_valid_o,
  input logic                 illegal_o,
  input logic [CLASS_W-1:0]   op_class_o,
  input logic [OP_W-1:0]      op_code_o,
  input logic [REG_IDX_W-1:0] rd_idx_o,
  input logic [XLEN-1:0]      op_a_o,
  input logic [XLEN-1:0]      op_b_o,
  input logic [XLEN-1:0]      op_c_o,
  input logic [XLEN-1:0]      imm_u_o,
  input logic [XLEN-1:0]      imm_i_s_o,
  input logic [XLEN-1:0]      imm_i_u_o,
  input logic [XLEN-1:0]      imm_b_o
);

  // R1
  valid_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid_i |=> dec_valid_o);

  // R1
  valid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid_i |=> !dec_valid_o);

  // R2
  rd_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid_i && instr_i[6:0] == 7'b0110011)
      |=> (rd_idx_o == REG_IDX_W'($past(instr_i[11:7])) && !illegal_o));

  // R3
  mds_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid_i && instr_i[6:0] == 7'b0110011 &&
     (instr_i[25] || instr_i[13:12] == 2'b01))
      |=> (op_class_o == CLASS_W'(1)));

  // R7
  imm_u_chk: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid_i |=> (imm_u_o[31:12] == $past(instr_i[31:12]) && imm_u_o[11:0] == 12'h0));

  // R10
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid_o && illegal_o) |-> (op_class_o == '0 && op_code_o == '0 && rd_idx_o == '0));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid_i |=> ($stable(op_code_o) && $stable(imm_b_o) && $stable(illegal_o)));

endmodule

bind rv_rtype_decoder rv_rtype_decoder_chk #(
  .XLEN(XLEN), .REG_IDX_W(REG_IDX_W), .OP_W(OP_W), .CLASS_W(CLASS_W)
) u_chk (.*);

// File: tb/test_rv_rtype_decoder.sv
`timescale 1ns/1ps
module test_rv_rtype_decoder;

  typedef struct packed {
    logic        ill;
    logic [4:0]  cls;
    logic [3:0]  op;
    logic [5:0]  rd;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] u;
    logic [31:0] is;
    logic [31:0] iu;
    logic [31:0] bi;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr_i = '0;
  logic        instr_valid_i = 1'b0;
  logic        dec_valid_o, illegal_o;
  logic [4:0]  op_class_o;
  logic [3:0]  op_code_o;
  logic [5:0]  rd_idx_o;
  logic [31:0] op_a_o, op_b_o, op_c_o, imm_u_o, imm_i_s_o, imm_i_u_o, imm_b_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rv_rtype_decoder i_rv_rtype_decoder (
    .clk(clk), .rst_n(rst_n), .instr_i(instr_i), .instr_valid_i(instr_valid_i),
    .dec_valid_o(dec_valid_o), .illegal_o(illegal_o), .op_class_o(op_class_o),
    .op_code_o(op_code_o), .rd_idx_o(rd_idx_o), .op_a_o(op_a_o), .op_b_o(op_b_o),
    .op_c_o(op_c_o), .imm_u_o(imm_u_o), .imm_i_s_o(imm_i_s_o),
    .imm_i_u_o(imm_i_u_o), .imm_b_o(imm_b_o)
  );

  function automatic exp_t model(logic [31:0] w);
    exp_t e;
    e = '0;
    e.u  = {w[31:12], 12'h000};
    e.is = {{20{w[31]}}, w[31:20]};
    e.iu = {20'h0, w[31:20]};
    e.bi = {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
    if (w[6:0] != 7'b0110011) begin
      e.ill = 1'b1;
    end else begin
      e.rd = {1'b0, w[11:7]};
      e.a  = {27'h0, w[19:15]};
      e.b  = {27'h0, w[24:20]};
      if (w[25]) begin
        e.cls = 5'd1;
        e.op  = {1'b0, w[14:12]};
      end else begin
        case (w[14:12])
          3'b000: e.op = w[30] ? 4'd1 : 4'd0;
          3'b001: begin e.op = 4'd7; e.cls = 5'd1; end
          3'b010: e.op = 4'd5;
          3'b011: e.op = 4'd6;
          3'b100: e.op = 4'd4;
          3'b101: begin e.op = w[30] ? 4'd9 : 4'd8; e.cls = 5'd1; end
          3'b110: e.op = 4'd3;
          default: e.op = 4'd2;
        endcase
      end
    end
    return e;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic chk_all(exp_t e, string tag);
    chk({"R1 ", tag}, {31'h0, dec_valid_o}, 32'd1);
    chk({"R10 illegal ", tag}, {31'h0, illegal_o}, {31'h0, e.ill});
    chk({"R3 class ", tag}, {27'h0, op_class_o}, {27'h0, e.cls});
    chk({"R4/R5/R6 op ", tag}, {28'h0, op_code_o}, {28'h0, e.op});
    chk({"R2 rd ", tag}, {26'h0, rd_idx_o}, {26'h0, e.rd});
    chk({"R2 a ", tag}, op_a_o, e.a);
    chk({"R2 b ", tag}, op_b_o, e.b);
    chk({"R2 c ", tag}, op_c_o, 32'h0);
    chk({"R7 ", tag}, imm_u_o, e.u);
    chk({"R8 s ", tag}, imm_i_s_o, e.is);
    chk({"R8 u ", tag}, imm_i_u_o, e.iu);
    chk({"R9 ", tag}, imm_b_o, e.bi);
  endtask

  task automatic apply(logic [31:0] w, string tag);
    exp_t e;
    e = model(w);
    @(negedge clk);
    instr_i = w;
    instr_valid_i = 1'b1;
    @(negedge clk);
    instr_valid_i = 1'b0;
    instr_i = $urandom();
    chk_all(e, tag);
    @(negedge clk);
    chk({"R1 pulse ends ", tag}, {31'h0, dec_valid_o}, 32'd0);
    chk({"R11 hold op ", tag}, {28'h0, op_code_o}, {28'h0, e.op});
    chk({"R11 hold b-imm ", tag}, imm_b_o, e.bi);
    chk({"R11 hold rd ", tag}, {26'h0, rd_idx_o}, {26'h0, e.rd});
  endtask

  function automatic logic [31:0] rr(logic [6:0] f7, logic [4:0] rs2, logic [4:0] rs1,
                                     logic [2:0] f3, logic [4:0] rd);
    return {f7, rs2, rs1, f3, rd, 7'b0110011};
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    instr_valid_i = 1'b1;
    instr_i = rr(7'h00, 5'd3, 5'd2, 3'b000, 5'd1);
    repeat (3) @(negedge clk);
    chk("R1 reset valid low", {31'h0, dec_valid_o}, 32'd0);
    chk("R1 reset op zero", {28'h0, op_code_o}, 32'd0);
    chk("R1 reset imm zero", imm_u_o, 32'd0);
    instr_valid_i = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset valid low", {31'h0, dec_valid_o}, 32'd0);

    apply(rr(7'h00, 5'd5, 5'd4, 3'b000, 5'd31), "R6 ADD");
    apply(rr(7'h20, 5'd31, 5'd31, 3'b000, 5'd0), "R6 SUB");
    apply(rr(7'h00, 5'd1, 5'd2, 3'b010, 5'd3), "R6 SLT");
    apply(rr(7'h00, 5'd1, 5'd2, 3'b011, 5'd3), "R6 SLTU");
    apply(rr(7'h00, 5'd6, 5'd7, 3'b100, 5'd8), "R6 XOR");
    apply(rr(7'h00, 5'd6, 5'd7, 3'b110, 5'd8), "R6 OR");
    apply(rr(7'h00, 5'd6, 5'd7, 3'b111, 5'd8), "R6 AND");
    apply(rr(7'h5e, 5'd6, 5'd7, 3'b111, 5'd8), "R6 AND odd funct7 bits");
    apply(rr(7'h00, 5'd9, 5'd10, 3'b001, 5'd11), "R4 SLL");
    apply(rr(7'h20, 5'd9, 5'd10, 3'b001, 5'd11), "R4 SLL bit30");
    apply(rr(7'h00, 5'd9, 5'd10, 3'b101, 5'd11), "R4 SRL");
    apply(rr(7'h20, 5'd9, 5'd10, 3'b101, 5'd11), "R4 SRA");
    for (int f = 0; f < 8; f++) begin
      apply(rr(7'h01, 5'(f + 12), 5'(f), 3'(f), 5'(31 - f)), "R5 mul/div");
      apply(rr(7'h21, 5'(f), 5'(f + 3), 3'(f), 5'(f)), "R5 mul/div bit30");
    end
    apply(32'h0000_0000, "R10 zero word");
    apply(32'hFFFF_FFFF, "R10 all ones");
    apply(32'h8000_0013, "R10 I-type");
    apply(32'h7FFF_F0B7, "R10 U-type");
    apply(32'h8000_0F63, "R9 branch neg");

    for (int n = 0; n < 400; n++) begin
      logic [31:0] w;
      w = $urandom();
      if (n % 2 == 0) w[6:0] = 7'b0110011;
      apply(w, "random");
    end

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule